// File: doc/BRIEF.md
# Serial ADC Acquisition Controller

This block sits in a host FPGA and runs a serial sampling ADC that has an active-low convert-start input, a busy output and a two-wire read port (serial clock in, serial data out). A sample-rate tick or a software trigger starts a conversion. The block then drives a convert-start pulse and waits for busy to rise and fall. After that it clocks out one 16-bit frame and hands the 12-bit result to the host on a valid/ready port.

The pulse shape picks the converter's power mode. In the fast mode, convert-start is released after a fixed number of clocks, well before the conversion ends. In the power-saving mode it stays low until busy has fallen, so the converter sleeps once its result is ready, and the rising edge wakes it for the next sample. The serial clock is divided down from the system clock. Data is taken on each falling edge, which is also the edge on which the converter launches its next bit. The clock is left low between frames.

Two checks guard the link. Busy must rise within a short window and fall within a limit set at run time; otherwise the block pulses an error and drops the frame. Non-zero padding bits mark the delivered sample with a framing-error flag.

Top module: `adc_acq_ctrl`

## Requirements
- R1: With `pd_mode` low at the trigger (fast mode), `adc_cnv_n` is low for exactly `CNV_LOW_CYC` clock cycles and is back high before busy falls.
- R2: With `pd_mode` high at the trigger (power-saving mode), `adc_cnv_n` stays low until the synchronized busy has fallen, and only then returns high. It is never low for fewer than `CNV_LOW_CYC` cycles.
- R3: A one-cycle `sample_tick` or `sw_trig` seen while the block is idle and no sample is waiting drives `adc_cnv_n` low on the next clock edge. Triggers that arrive during a conversion or readout, or while `smp_valid` is high, are ignored.
- R4: Readout starts only after busy has fallen. Each frame has exactly 16 serial clock pulses, each high for `SCLK_HALF` system clocks, and `adc_sclk` is low whenever no frame is in progress.
- R5: `adc_sdata` is sampled in the clock cycle in which `adc_sclk` falls, MSB first. Of the 16 bits, the first four are padding and the last twelve form `smp_data`, bit 11 first.
- R6: If any of the four padding bits is 1, `smp_lead_err` is high together with that sample. The 12-bit sample is still delivered unchanged.
- R7: Once `smp_valid` is high, it and `smp_data` stay unchanged until a cycle with `smp_ready` high, after which `smp_valid` goes low.
- R8: If busy has not risen within `BUSY_RISE_MAX` cycles of `adc_cnv_n` falling, `tmo_err` pulses for one cycle, `adc_cnv_n` returns high, no serial clock is produced and no sample is delivered.
- R9: If busy stays high for `busy_lim` cycles of the conversion, `tmo_err` pulses for one cycle, `adc_cnv_n` returns high and no readout or sample follows.
- R10: While and after reset, `adc_cnv_n` is high, `adc_sclk` is low, and `smp_valid` and `tmo_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_tick | input | 1 | Sample-rate trigger pulse |
| sw_trig | input | 1 | Software trigger pulse |
| pd_mode | input | 1 | 1 = power-saving pulse shape, 0 = fast mode; taken at trigger |
| busy_lim | input | TMO_W | Maximum busy-high duration in clock cycles |
| adc_cnv_n | output | 1 | Active-low convert-start to the ADC |
| adc_busy | input | 1 | Busy from the ADC (asynchronous) |
| adc_sclk | output | 1 | Generated serial clock |
| adc_sdata | input | 1 | Serial data from the ADC |
| smp_valid | output | 1 | Sample available |
| smp_ready | input | 1 | Host accepts the sample |
| smp_data | output | 12 | Conversion result, straight binary |
| smp_lead_err | output | 1 | Padding bits of this frame were non-zero |
| tmo_err | output | 1 | One-cycle pulse on a busy timeout |

## Verification
The bench uses a behavioural converter model. The model records the convert-start level at the moment busy falls and measures the pulse width. A design that used the wrong pulse shape for a mode, for example one that released convert-start early in power-saving mode, is caught that way. Each frame's serial clock pulses and high times are counted, so an off-by-one in the bit counter or a clock left high after the frame shows up. The model changes data a little after each falling edge, so a design that sampled one edge late would deliver shifted data. Further directed cases cover a busy that never rises, a busy that never falls within the limit, and triggers sent while a sample is waiting; a design that hung, read garbage or started a stray conversion in these cases is reported.

// File: rtl/adc_acq_pkg.sv
package adc_acq_pkg;

    localparam int FRAME_BITS  = 16;
    localparam int LEAD_BITS   = 4;
    localparam int SAMPLE_BITS = FRAME_BITS - LEAD_BITS;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_CONV,
        SQ_READ
    } seq_state_t;

    typedef struct packed {
        logic [LEAD_BITS-1:0]   lead;
        logic [SAMPLE_BITS-1:0] data;
    } frame_t;

    function automatic logic lead_bad(frame_t f);
        return |f.lead;
    endfunction

endpackage

// File: rtl/acq_sync.sv
module acq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign q = d;
        end else begin : g_chain
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2+((STAGES==1)?1:0):0], d};
            end
            assign q = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
    import adc_acq_pkg::*;
#(
    parameter int CNV_LOW_CYC   = 4,
    parameter int BUSY_RISE_MAX = 8,
    parameter int TMO_W         = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig,
    input  logic             pd_mode,
    input  logic             busy_s,
    input  logic [TMO_W-1:0] busy_lim,
    input  logic             rd_done,
    output logic             cnv_n,
    output logic             rd_start,
    output logic             tmo,
    output logic             idle
);
    localparam logic [TMO_W-1:0] LOW_LAST  = TMO_W'(CNV_LOW_CYC - 1);
    localparam logic [TMO_W-1:0] RISE_LAST = TMO_W'(BUSY_RISE_MAX - 1);

    seq_state_t       st;
    logic [TMO_W-1:0] cnt;
    logic             seen;
    logic             mode_q;

    assign idle = (st == SQ_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= SQ_IDLE;
            cnv_n    <= 1'b1;
            cnt      <= '0;
            seen     <= 1'b0;
            mode_q   <= 1'b0;
            tmo      <= 1'b0;
            rd_start <= 1'b0;
        end else begin
            tmo      <= 1'b0;
            rd_start <= 1'b0;
            case (st)
                SQ_IDLE: begin
                    if (trig) begin
                        st     <= SQ_CONV;
                        cnv_n  <= 1'b0;
                        cnt    <= '0;
                        seen   <= 1'b0;
                        mode_q <= pd_mode;
                    end
                end
                SQ_CONV: begin
                    if (cnt != '1) cnt <= cnt + 1'b1;
                    seen <= seen | busy_s;
                    if (!mode_q && cnt == LOW_LAST) cnv_n <= 1'b1;
                    if (seen && !busy_s && cnt >= LOW_LAST) begin
                        cnv_n    <= 1'b1;
                        rd_start <= 1'b1;
                        st       <= SQ_READ;
                    end else if ((!seen && !busy_s && cnt >= RISE_LAST) ||
                                 (seen && busy_s && cnt >= busy_lim)) begin
                        cnv_n <= 1'b1;
                        tmo   <= 1'b1;
                        st    <= SQ_IDLE;
                    end
                end
                SQ_READ: begin
                    if (rd_done) st <= SQ_IDLE;
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    // pulse-width monitor for the checks below
    logic [TMO_W-1:0] low_len;
    always_ff @(posedge clk) begin
        if (rst || cnv_n)        low_len <= '0;
        else if (low_len != '1)  low_len <= low_len + 1'b1;
    end

    AST_CNV_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(cnv_n) && !tmo |-> $past(low_len) >= LOW_LAST); // R1
    AST_PD_WAKE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        mode_q && $rose(cnv_n) && !tmo |-> !$past(busy_s)); // R2
    AST_READ_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
        rd_start |-> cnv_n); // R4
endmodule

// File: rtl/acq_serial_rx.sv
module acq_serial_rx
    import adc_acq_pkg::*;
#(
    parameter int SCLK_HALF = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  sdata,
    output logic                  sclk,
    output logic                  done,
    output logic [FRAME_BITS-1:0] word
);
    localparam int DIV_W  = $clog2(SCLK_HALF + 1);
    localparam int FALL_W = $clog2(FRAME_BITS + 1);
    localparam logic [DIV_W-1:0]  DIV_LAST  = DIV_W'(SCLK_HALF - 1);
    localparam logic [FALL_W-1:0] FALL_LAST = FALL_W'(FRAME_BITS - 1);

    logic              active;
    logic [DIV_W-1:0]  div;
    logic [FALL_W-1:0] falls;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            div    <= '0;
            falls  <= '0;
            sclk   <= 1'b0;
            done   <= 1'b0;
            word   <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                active <= 1'b1;
                div    <= '0;
                falls  <= '0;
                sclk   <= 1'b0;
            end else if (active) begin
                if (div == DIV_LAST) begin
                    div  <= '0;
                    sclk <= ~sclk;
                    if (sclk) begin
                        // old bit is still held on the line at this edge
                        word  <= {word[FRAME_BITS-2:0], sdata};
                        falls <= falls + 1'b1;
                        if (falls == FALL_LAST) begin
                            active <= 1'b0;
                            done   <= 1'b1;
                        end
                    end
                end else begin
                    div <= div + 1'b1;
                end
            end
        end
    end

    AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (rst)
        !active |-> !sclk); // R4
    AST_FALL_LIMIT: assert property (@(posedge clk) disable iff (rst)
        falls <= FALL_W'(FRAME_BITS)); // R4
endmodule

// File: rtl/adc_acq_ctrl.sv
module adc_acq_ctrl
    import adc_acq_pkg::*;
#(
    parameter int CNV_LOW_CYC   = 4,
    parameter int SCLK_HALF     = 5,
    parameter int BUSY_RISE_MAX = 8,
    parameter int SYNC_STAGES   = 2,
    parameter int TMO_W         = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   sample_tick,
    input  logic                   sw_trig,
    input  logic                   pd_mode,
    input  logic [TMO_W-1:0]       busy_lim,
    output logic                   adc_cnv_n,
    input  logic                   adc_busy,
    output logic                   adc_sclk,
    input  logic                   adc_sdata,
    output logic                   smp_valid,
    input  logic                   smp_ready,
    output logic [SAMPLE_BITS-1:0] smp_data,
    output logic                   smp_lead_err,
    output logic                   tmo_err
);
    logic                  busy_s;
    logic                  seq_idle;
    logic                  rd_start;
    logic                  rd_done;
    logic [FRAME_BITS-1:0] rx_word;
    logic                  trig_ok;
    frame_t                fr;

    assign trig_ok = (sample_tick | sw_trig) & seq_idle & ~smp_valid;
    assign fr      = frame_t'(rx_word);

    acq_sync #(.STAGES(SYNC_STAGES)) u_busy_sync (
        .clk (clk),
        .rst (rst),
        .d   (adc_busy),
        .q   (busy_s)
    );

    acq_sequencer #(
        .CNV_LOW_CYC   (CNV_LOW_CYC),
        .BUSY_RISE_MAX (BUSY_RISE_MAX),
        .TMO_W         (TMO_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .trig     (trig_ok),
        .pd_mode  (pd_mode),
        .busy_s   (busy_s),
        .busy_lim (busy_lim),
        .rd_done  (rd_done),
        .cnv_n    (adc_cnv_n),
        .rd_start (rd_start),
        .tmo      (tmo_err),
        .idle     (seq_idle)
    );

    acq_serial_rx #(.SCLK_HALF(SCLK_HALF)) u_rx (
        .clk   (clk),
        .rst   (rst),
        .start (rd_start),
        .sdata (adc_sdata),
        .sclk  (adc_sclk),
        .done  (rd_done),
        .word  (rx_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_valid    <= 1'b0;
            smp_data     <= '0;
            smp_lead_err <= 1'b0;
        end else if (rd_done) begin
            smp_valid    <= 1'b1;
            smp_data     <= fr.data;
            smp_lead_err <= lead_bad(fr);
        end else if (smp_valid && smp_ready) begin
            smp_valid    <= 1'b0;
        end
    end

    AST_SCLK_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        adc_sclk |-> !busy_s); // R4
    AST_HOLD_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        smp_valid && !smp_ready |=> smp_valid && $stable(smp_data) && $stable(smp_lead_err)); // R7
    AST_NO_SAMPLE_ON_TMO: assert property (@(posedge clk) disable iff (rst)
        tmo_err |-> !smp_valid && !adc_sclk); // R8
    AST_IDLE_OUTPUTS: assert property (@(posedge clk) disable iff (rst)
        seq_idle |-> adc_cnv_n && !adc_sclk); // R10
endmodule

// File: tb/adc_acq_ctrl_test.sv
module adc_acq_ctrl_test;
    localparam int CNV_LOW_CYC = 4;
    localparam int SCLK_HALF   = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sample_tick = 1'b0, sw_trig = 1'b0, pd_mode = 1'b0;
    logic [15:0] busy_lim = 16'd1000;
    logic        adc_cnv_n, adc_sclk, tmo_err, smp_valid, smp_lead_err;
    logic        adc_busy = 1'b0, adc_sdata = 1'b0, smp_ready = 1'b0;
    logic [11:0] smp_data;

    adc_acq_ctrl #(.CNV_LOW_CYC(CNV_LOW_CYC), .SCLK_HALF(SCLK_HALF)) uut (
        .clk(clk), .rst(rst), .sample_tick(sample_tick), .sw_trig(sw_trig),
        .pd_mode(pd_mode), .busy_lim(busy_lim), .adc_cnv_n(adc_cnv_n),
        .adc_busy(adc_busy), .adc_sclk(adc_sclk), .adc_sdata(adc_sdata),
        .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
        .smp_lead_err(smp_lead_err), .tmo_err(tmo_err));

    always #5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---- converter model ----
    logic [15:0] adc_word = 16'h0;
    logic [15:0] adc_sh   = 16'h0;
    bit          adc_en   = 1;
    int          conv_len = 80;
    bit          low_at_end = 0;
    longint      t_fall = 0, cnv_width = 0;
    int          cnv_falls = 0, sclk_pulses = 0, sclk_bad = 0, tmo_cnt = 0;
    longint      t_sclk = 0;

    always @(negedge adc_cnv_n) begin
        t_fall = $time;
        cnv_falls++;
        if (adc_en) begin
            #1 adc_busy = 1'b1;
            repeat (conv_len) @(posedge clk);
            #1;
            low_at_end = !adc_cnv_n;
            adc_sh     = adc_word;
            adc_sdata  = adc_sh[15];
            adc_busy   = 1'b0;
        end
    end
    always @(posedge adc_cnv_n) cnv_width = $time - t_fall;
    always @(posedge adc_sclk) begin
        sclk_pulses++;
        t_sclk = $time;
    end
    always @(negedge adc_sclk) begin
        if ($time - t_sclk != SCLK_HALF * 10) sclk_bad++;
        #2;
        adc_sh    = {adc_sh[14:0], 1'b0};
        adc_sdata = adc_sh[15];
    end
    always @(posedge clk) if (!rst && tmo_err) tmo_cnt++;

    // {pd_mode, use_tick, 16-bit frame}
    localparam logic [17:0] VECS [6] = '{
        {1'b0, 1'b0, 16'h0ABC},
        {1'b0, 1'b1, 16'h0FFF},
        {1'b1, 1'b0, 16'h0000},
        {1'b1, 1'b1, 16'h0800},
        {1'b0, 1'b0, 16'h9123},
        {1'b1, 1'b0, 16'h1001}
    };

    task automatic wait_valid(output bit got);
        got = 0;
        for (int i = 0; i < 3000 && !got; i++) begin
            @(negedge clk);
            if (smp_valid) got = 1;
        end
    endtask

    task automatic take_sample();
        smp_ready = 1'b1;
        @(negedge clk);
        smp_ready = 1'b0;
        chk(!smp_valid, "R7", "valid clears after ready", smp_valid, 0);
    endtask

    task automatic run_vec(input logic [17:0] v, input bit hold_test);
        bit got;
        @(negedge clk);
        pd_mode     = v[17];
        adc_word    = v[15:0];
        sclk_pulses = 0;
        sclk_bad    = 0;
        if (v[16]) sample_tick = 1'b1; else sw_trig = 1'b1;
        @(negedge clk);
        sample_tick = 1'b0;
        sw_trig     = 1'b0;
        chk(!adc_cnv_n, "R3", "cnv_n low after trigger", adc_cnv_n, 0);
        wait_valid(got);
        chk(got, "R5", "sample arrived", got, 1);
        chk(smp_data == v[11:0], "R5", "sample data", smp_data, v[11:0]);
        chk(smp_lead_err == (v[15:12] != 0), "R6", "lead error flag",
            smp_lead_err, v[15:12] != 0);
        chk(sclk_pulses == 16, "R4", "sclk pulse count", sclk_pulses, 16);
        chk(sclk_bad == 0, "R4", "sclk high width faults", sclk_bad, 0);
        chk(!adc_sclk, "R4", "sclk parked low", adc_sclk, 0);
        if (v[17]) begin
            chk(low_at_end, "R2", "cnv_n low at busy fall", low_at_end, 1);
            chk(cnv_width > conv_len * 10, "R2", "cnv_n held past conversion",
                cnv_width, conv_len * 10);
        end else begin
            chk(!low_at_end, "R1", "cnv_n high at busy fall", low_at_end, 0);
            chk(cnv_width == CNV_LOW_CYC * 10, "R1", "cnv_n pulse width",
                cnv_width, CNV_LOW_CYC * 10);
        end
        if (hold_test) begin
            for (int k = 0; k < 4; k++) @(negedge clk);
            chk(smp_valid && smp_data == v[11:0], "R7", "sample held without ready",
                smp_data, v[11:0]);
        end
        take_sample();
    endtask

    initial begin
        int falls0, tmo0;
        bit got;
        repeat (3) @(negedge clk);
        chk(adc_cnv_n && !adc_sclk && !smp_valid && !tmo_err, "R10",
            "outputs during reset", {adc_cnv_n, adc_sclk, smp_valid, tmo_err}, 4'b1000);
        rst = 1'b0;
        @(negedge clk);
        chk(adc_cnv_n && !adc_sclk && !smp_valid && !tmo_err, "R10",
            "outputs after reset", {adc_cnv_n, adc_sclk, smp_valid, tmo_err}, 4'b1000);

        foreach (VECS[i]) run_vec(VECS[i], i == 1);

        // R3: trigger while a sample waits, and during conversion
        @(negedge clk);
        adc_word = 16'h0555; pd_mode = 1'b0; sw_trig = 1'b1;
        @(negedge clk);
        sw_trig = 1'b0;
        repeat (20) @(negedge clk);
        sample_tick = 1'b1;                      // in conversion: ignored
        @(negedge clk);
        sample_tick = 1'b0;
        wait_valid(got);
        falls0 = cnv_falls;
        sw_trig = 1'b1;                          // sample waiting: ignored
        @(negedge clk);
        sw_trig = 1'b0;
        repeat (20) @(negedge clk);
        chk(cnv_falls == falls0 && adc_cnv_n, "R3", "trigger ignored while pending",
            cnv_falls, falls0);
        chk(smp_data == 12'h555, "R3", "pending sample intact", smp_data, 12'h555);
        take_sample();
        repeat (5) @(negedge clk);
        chk(cnv_falls == falls0, "R3", "no conversion from earlier ignored triggers",
            cnv_falls, falls0);

        // R8: busy never rises
        adc_en = 0; tmo0 = tmo_cnt; sclk_pulses = 0;
        sw_trig = 1'b1;
        @(negedge clk);
        sw_trig = 1'b0;
        repeat (30) @(negedge clk);
        chk(tmo_cnt == tmo0 + 1, "R8", "rise timeout pulse count", tmo_cnt, tmo0 + 1);
        chk(adc_cnv_n && !smp_valid && sclk_pulses == 0, "R8", "no sample after rise timeout",
            {adc_cnv_n, smp_valid, sclk_pulses[0]}, 3'b100);
        adc_en = 1;

        // R9: busy stays high past the limit
        conv_len = 200; busy_lim = 16'd50; tmo0 = tmo_cnt; sclk_pulses = 0;
        pd_mode = 1'b1;
        sw_trig = 1'b1;
        @(negedge clk);
        sw_trig = 1'b0;
        repeat (100) @(negedge clk);
        chk(tmo_cnt == tmo0 + 1, "R9", "fall timeout pulse count", tmo_cnt, tmo0 + 1);
        chk(adc_cnv_n, "R9", "cnv_n released on fall timeout", adc_cnv_n, 1);
        repeat (160) @(negedge clk);
        chk(!adc_busy && !smp_valid && sclk_pulses == 0, "R9", "no readout after fall timeout",
            sclk_pulses, 0);
        conv_len = 80; busy_lim = 16'd1000;

        // recovery after the timeouts
        run_vec({1'b0, 1'b1, 16'h07E1}, 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule